// File: doc/BRIEF.md
# Load-Use Pipeline Interlock Unit

This unit guards a five-stage in-order pipeline (fetch, decode, execute, memory access, write-back) against using a loaded value before it exists. A load writes its destination register only at write-back. So while a load sits in memory access, the instruction entering execute may need a value that is not ready yet. Each cycle the unit compares the decoded fields of that execute-stage instruction with the destination of the load in memory access. When they collide, it raises a stall request.

The pipeline reacts to the stall request in a fixed way. It freezes its fetch, decode and execute registers and pushes a bubble into memory access. The stall covers every memory-access cycle of the load, as stretched by the memory-busy input, plus a fixed number of refetch cycles after the load leaves. When the waiting instruction uses the loaded register as its address pointer, a separate hold keeps its address generator from starting until the load's memory access has finished.

Two instruction classes are exempt from parts of the check. One is a load that overwrites the same register. The other is a post-increment multiply-accumulate whose first memory pointer is the loaded register. A load into the status register is a separate case: it interlocks only against instructions that consume a flag.

Top module: `load_use_interlock`

## Requirements
- R1: After reset, with no load present (ld_valid_i=0) and no execute instruction (ex_valid_i=0), stall_o and agen_hold_o are 0.
- R2: With ld_valid_i=1, ld_dst_sr_i=0 and ex_valid_i=1, stall_o is 1 in the same cycle when operand A (ex_src_a_use_i=1) or operand B (ex_src_b_use_i=1) names the register ld_dst_i.
- R3: With ld_valid_i=1, ld_dst_sr_i=0 and ex_valid_i=1, stall_o is 1 when the execute instruction writes ld_dst_i (ex_dst_we_i=1, ex_dst_i=ld_dst_i) and belongs to neither the load class nor the multiply-accumulate class. This holds even when the instruction reads no operand.
- R4: When ld_dst_sr_i=1, the load targets the status register. In that case stall_o is 1 if and only if ex_flag_rd_i=1, and the general-register fields are not compared against ld_dst_i.
- R5: When ex_is_load_i=1, a destination equal to ld_dst_i causes no stall. A pointer (ex_ptr_use_i=1) or operand equal to ld_dst_i still stalls.
- R6: When ex_is_mac_i=1, the first-pointer match and the destination match are ignored, so stall_o and agen_hold_o stay 0. A match on operand A or operand B still stalls.
- R7: stall_o stays 1 in every cycle in which a hazard is present. A load with k cycles of mem_busy_i=1 followed by its final cycle (mem_busy_i=0) therefore stalls k+1 cycles. After that, stall_o stays 1 for TAIL_CYCLES more cycles (default 1), so a total of k+2 cycles by default.
- R8: agen_hold_o is 1 exactly in the cycles where the load is in memory access and a non-multiply-accumulate execute instruction uses ld_dst_i as its address pointer. It is 0 during the trailing refetch cycles, and agen_hold_o=1 always comes with stall_o=1.
- R9: No interlock is raised when ld_valid_i=0 (the dependent instruction is two or more slots behind the load), when ex_valid_i=0, or when every use/write bit for the matching field is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ld_valid_i | input | 1 | A load occupies memory access |
| ld_dst_i | input | 4 | Load destination general register |
| ld_dst_sr_i | input | 1 | Load destination is the status register |
| mem_busy_i | input | 1 | Load memory access continues next cycle |
| ex_valid_i | input | 1 | Valid instruction entering execute |
| ex_src_a_i | input | 4 | Operand A register |
| ex_src_a_use_i | input | 1 | Operand A is read |
| ex_src_b_i | input | 4 | Operand B register |
| ex_src_b_use_i | input | 1 | Operand B is read |
| ex_dst_i | input | 4 | Destination register |
| ex_dst_we_i | input | 1 | Destination is written |
| ex_ptr_i | input | 4 | Address pointer / first memory pointer register |
| ex_ptr_use_i | input | 1 | Pointer is used for a memory access |
| ex_flag_rd_i | input | 1 | Instruction consumes a status flag |
| ex_is_load_i | input | 1 | Instruction belongs to the load class |
| ex_is_mac_i | input | 1 | Instruction is post-increment multiply-accumulate |
| stall_o | output | 1 | Stall request to fetch, decode and execute |
| agen_hold_o | output | 1 | Hold on the address generator |

## Verification
The hardest case to reach from the ports is the stall length. It depends on a load staying in memory access across several busy cycles, on the pipeline then dropping ld_valid_i while the dependent instruction keeps its fields, and on the trailing refetch cycle coming from internal state alone. The bench builds this sequence explicitly. It holds the load and the consumer steady through the mem_busy_i cycles, then presents the same consumer with no load, and expects stall_o to stay high for one more cycle with agen_hold_o already low. The exemption cases are paired with near-identical instructions that must still stall. This shows that each exemption removes only its own term.

// File: rtl/lu_pkg.sv
package lu_pkg;
  localparam int unsigned RD_PORTS = 3;
  localparam int unsigned PORT_SRC_A = 0;
  localparam int unsigned PORT_SRC_B = 1;
  localparam int unsigned PORT_PTR   = 2;

  typedef struct packed {
    logic src_raw;
    logic dst_waw;
    logic sr_flag;
    logic ptr_raw;
  } hz_cause_t;
endpackage

// File: rtl/lu_reg_cmp.sv
module lu_reg_cmp #(
  parameter int unsigned REG_W = 4,
  parameter int unsigned PORTS = 3
) (
  input  logic [REG_W-1:0]            ref_i,
  input  logic                        ref_ok_i,
  input  logic [PORTS-1:0][REG_W-1:0] idx_i,
  input  logic [PORTS-1:0]            use_i,
  output logic [PORTS-1:0]            hit_o
);
  for (genvar g = 0; g < PORTS; g++) begin : g_port
    assign hit_o[g] = ref_ok_i & use_i[g] & (idx_i[g] == ref_i);
  end
endmodule

// File: rtl/lu_hazard_eval.sv
module lu_hazard_eval
  import lu_pkg::*;
(
  input  logic [RD_PORTS-1:0] rd_hit_i,
  input  logic                wr_hit_i,
  input  logic                sr_ok_i,
  input  logic                flag_rd_i,
  input  logic                is_load_i,
  input  logic                is_mac_i,
  output hz_cause_t           cause_o
);
  always_comb begin
    cause_o.src_raw = rd_hit_i[PORT_SRC_A] | rd_hit_i[PORT_SRC_B];
    // multiply-accumulate first pointer is exempt
    cause_o.ptr_raw = rd_hit_i[PORT_PTR] & ~is_mac_i;
    // same-destination load and mac pointer writeback are exempt
    cause_o.dst_waw = wr_hit_i & ~is_load_i & ~is_mac_i;
    cause_o.sr_flag = sr_ok_i & flag_rd_i;
  end
endmodule

// File: rtl/lu_stall_ctl.sv
module lu_stall_ctl
  import lu_pkg::*;
#(
  parameter int unsigned TAIL_CYCLES = 1
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  hz_cause_t cause_i,
  input  logic      mem_busy_i,
  output logic      stall_o,
  output logic      hold_o
);
  localparam int unsigned TAIL_W = $clog2(TAIL_CYCLES + 1);

  logic              hazard;
  logic [TAIL_W-1:0] tail_q;
  logic [TAIL_W-1:0] tail_d;

  assign hazard = |cause_i;

  always_comb begin
    tail_d = tail_q;
    if (hazard && !mem_busy_i)      tail_d = TAIL_W'(TAIL_CYCLES);
    else if (tail_q != '0)          tail_d = tail_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tail_q <= '0;
    else         tail_q <= tail_d;
  end

  assign stall_o = hazard | (tail_q != '0);
  assign hold_o  = cause_i.ptr_raw;
endmodule

// File: rtl/load_use_interlock.sv
module load_use_interlock
  import lu_pkg::*;
#(
  parameter int unsigned NUM_REGS    = 16,
  parameter int unsigned TAIL_CYCLES = 1,
  localparam int unsigned REG_W      = $clog2(NUM_REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ld_valid_i,
  input  logic [REG_W-1:0] ld_dst_i,
  input  logic             ld_dst_sr_i,
  input  logic             mem_busy_i,
  input  logic             ex_valid_i,
  input  logic [REG_W-1:0] ex_src_a_i,
  input  logic             ex_src_a_use_i,
  input  logic [REG_W-1:0] ex_src_b_i,
  input  logic             ex_src_b_use_i,
  input  logic [REG_W-1:0] ex_dst_i,
  input  logic             ex_dst_we_i,
  input  logic [REG_W-1:0] ex_ptr_i,
  input  logic             ex_ptr_use_i,
  input  logic             ex_flag_rd_i,
  input  logic             ex_is_load_i,
  input  logic             ex_is_mac_i,
  output logic             stall_o,
  output logic             agen_hold_o
);
  logic                           gpr_ok;
  logic                           sr_ok;
  logic [RD_PORTS-1:0][REG_W-1:0] rd_idx;
  logic [RD_PORTS-1:0]            rd_use;
  logic [RD_PORTS-1:0]            rd_hit;
  logic [0:0][REG_W-1:0]          wr_idx;
  logic [0:0]                     wr_use;
  logic [0:0]                     wr_hit;
  hz_cause_t                      cause;

  assign gpr_ok = ld_valid_i & ex_valid_i & ~ld_dst_sr_i;
  assign sr_ok  = ld_valid_i & ex_valid_i & ld_dst_sr_i;

  always_comb begin
    rd_idx[PORT_SRC_A] = ex_src_a_i;
    rd_use[PORT_SRC_A] = ex_src_a_use_i;
    rd_idx[PORT_SRC_B] = ex_src_b_i;
    rd_use[PORT_SRC_B] = ex_src_b_use_i;
    rd_idx[PORT_PTR]   = ex_ptr_i;
    rd_use[PORT_PTR]   = ex_ptr_use_i;
    wr_idx[0]          = ex_dst_i;
    wr_use[0]          = ex_dst_we_i;
  end

  lu_reg_cmp #(.REG_W(REG_W), .PORTS(RD_PORTS)) u_rd_cmp (
    .ref_i   (ld_dst_i),
    .ref_ok_i(gpr_ok),
    .idx_i   (rd_idx),
    .use_i   (rd_use),
    .hit_o   (rd_hit)
  );

  lu_reg_cmp #(.REG_W(REG_W), .PORTS(1)) u_wr_cmp (
    .ref_i   (ld_dst_i),
    .ref_ok_i(gpr_ok),
    .idx_i   (wr_idx),
    .use_i   (wr_use),
    .hit_o   (wr_hit)
  );

  lu_hazard_eval u_eval (
    .rd_hit_i (rd_hit),
    .wr_hit_i (wr_hit[0]),
    .sr_ok_i  (sr_ok),
    .flag_rd_i(ex_flag_rd_i),
    .is_load_i(ex_is_load_i),
    .is_mac_i (ex_is_mac_i),
    .cause_o  (cause)
  );

  lu_stall_ctl #(.TAIL_CYCLES(TAIL_CYCLES)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cause_i   (cause),
    .mem_busy_i(mem_busy_i),
    .stall_o   (stall_o),
    .hold_o    (agen_hold_o)
  );
endmodule

// File: rtl/load_use_interlock_chk.sv
module load_use_interlock_chk #(
  parameter int unsigned REG_W = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ld_valid_i,
  input logic [REG_W-1:0] ld_dst_i,
  input logic             ld_dst_sr_i,
  input logic             mem_busy_i,
  input logic             ex_valid_i,
  input logic [REG_W-1:0] ex_ptr_i,
  input logic             ex_ptr_use_i,
  input logic             ex_flag_rd_i,
  input logic             ex_is_mac_i,
  input logic             stall_o,
  input logic             agen_hold_o
);
  // R8
  hold_implies_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agen_hold_o |-> stall_o);

  // R8
  hold_needs_live_ptr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    agen_hold_o |-> (ld_valid_i && ex_valid_i && ex_ptr_use_i && !ld_dst_sr_i
                     && !ex_is_mac_i && ex_ptr_i == ld_dst_i));

  // R4
  sr_flag_stall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ex_valid_i && ld_dst_sr_i && ex_flag_rd_i) |-> stall_o);

  // R7
  tail_after_last_ma_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_valid_i && ex_valid_i && ld_dst_sr_i && ex_flag_rd_i && !mem_busy_i) |=> stall_o);

  // R9
  no_hold_without_ex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ex_valid_i |-> !agen_hold_o);
endmodule

bind load_use_interlock load_use_interlock_chk #(.REG_W(REG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .ld_valid_i  (ld_valid_i),
  .ld_dst_i    (ld_dst_i),
  .ld_dst_sr_i (ld_dst_sr_i),
  .mem_busy_i  (mem_busy_i),
  .ex_valid_i  (ex_valid_i),
  .ex_ptr_i    (ex_ptr_i),
  .ex_ptr_use_i(ex_ptr_use_i),
  .ex_flag_rd_i(ex_flag_rd_i),
  .ex_is_mac_i (ex_is_mac_i),
  .stall_o     (stall_o),
  .agen_hold_o (agen_hold_o)
);

// File: tb/load_use_interlock_bench.sv
module load_use_interlock_bench;
  typedef struct {
    logic       ld_valid;
    logic [3:0] ld_dst;
    logic       ld_sr;
    logic       busy;
    logic       ex_valid;
    logic [3:0] src_a;
    logic       src_a_use;
    logic [3:0] src_b;
    logic       src_b_use;
    logic [3:0] dst;
    logic       dst_we;
    logic [3:0] ptr;
    logic       ptr_use;
    logic       flag_rd;
    logic       is_load;
    logic       is_mac;
  } stim_t;

  typedef struct {
    logic  stall;
    logic  hold;
    string tag;
  } exp_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ld_valid, ld_sr, busy, ex_valid, src_a_use, src_b_use, dst_we;
  logic       ptr_use, flag_rd, is_load, is_mac;
  logic [3:0] ld_dst, src_a, src_b, dst, ptr;
  logic       stall, hold;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 1'b0;
  exp_t q[$];

  always #2 clk = ~clk;

  load_use_interlock u_load_use_interlock (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_dst_i(ld_dst), .ld_dst_sr_i(ld_sr), .mem_busy_i(busy),
    .ex_valid_i(ex_valid), .ex_src_a_i(src_a), .ex_src_a_use_i(src_a_use),
    .ex_src_b_i(src_b), .ex_src_b_use_i(src_b_use), .ex_dst_i(dst), .ex_dst_we_i(dst_we),
    .ex_ptr_i(ptr), .ex_ptr_use_i(ptr_use), .ex_flag_rd_i(flag_rd),
    .ex_is_load_i(is_load), .ex_is_mac_i(is_mac),
    .stall_o(stall), .agen_hold_o(hold)
  );

  function automatic stim_t idle();
    stim_t s;
    s.ld_valid = 0; s.ld_dst = 4'd0; s.ld_sr = 0; s.busy = 0;
    s.ex_valid = 0; s.src_a = 4'd0; s.src_a_use = 0; s.src_b = 4'd0; s.src_b_use = 0;
    s.dst = 4'd0; s.dst_we = 0; s.ptr = 4'd0; s.ptr_use = 0; s.flag_rd = 0;
    s.is_load = 0; s.is_mac = 0;
    return s;
  endfunction

  // load r3 in MA, valid unrelated instruction in EX
  function automatic stim_t base_ld();
    stim_t s = idle();
    s.ld_valid = 1; s.ld_dst = 4'd3; s.ex_valid = 1;
    s.src_a = 4'd7; s.src_b = 4'd8; s.dst = 4'd9; s.ptr = 4'd10;
    return s;
  endfunction

  task automatic apply(input stim_t s);
    ld_valid = s.ld_valid; ld_dst = s.ld_dst; ld_sr = s.ld_sr; busy = s.busy;
    ex_valid = s.ex_valid; src_a = s.src_a; src_a_use = s.src_a_use;
    src_b = s.src_b; src_b_use = s.src_b_use; dst = s.dst; dst_we = s.dst_we;
    ptr = s.ptr; ptr_use = s.ptr_use; flag_rd = s.flag_rd;
    is_load = s.is_load; is_mac = s.is_mac;
  endtask

  task automatic drive(input stim_t s, input logic es, input logic eh, input string tag);
    exp_t e;
    @(negedge clk);
    apply(s);
    e.stall = es; e.hold = eh; e.tag = tag;
    q.push_back(e);
  endtask

  // one-cycle load then same consumer with load gone (tail)
  task automatic hazard_pair(input stim_t s, input logic eh, input string tag);
    stim_t t = s;
    drive(s, 1'b1, eh, tag);
    t.ld_valid = 0;
    drive(t, 1'b1, 1'b0, {tag, " tail R7"});
    drive(idle(), 1'b0, 1'b0, {tag, " after R7"});
  endtask

  task automatic quiet(input stim_t s, input string tag);
    drive(s, 1'b0, 1'b0, tag);
    drive(idle(), 1'b0, 1'b0, {tag, " idle"});
  endtask

  initial begin : monitor
    exp_t e;
    forever begin
      @(negedge clk);
      #1;
      if (q.size() != 0) begin
        e = q.pop_front();
        n_cmp++;
        if (stall !== e.stall || hold !== e.hold) begin
          n_bad++;
          $display("FAIL %s: stall/hold got %b/%b exp %b/%b", e.tag, stall, hold, e.stall, e.hold);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : driver
    stim_t s;
    stim_t t;
    apply(idle());
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1 reset state
    drive(idle(), 1'b0, 1'b0, "R1 reset idle");
    drive(idle(), 1'b0, 1'b0, "R1 reset idle 2");

    // R2 operand A / operand B
    s = base_ld(); s.src_a = 4'd3; s.src_a_use = 1;
    hazard_pair(s, 1'b0, "R2 src_a");
    s = base_ld(); s.src_b = 4'd3; s.src_b_use = 1;
    hazard_pair(s, 1'b0, "R2 src_b");
    s = base_ld(); s.ld_dst = 4'd0; s.src_a = 4'd0; s.src_a_use = 1;
    hazard_pair(s, 1'b0, "R2 reg0");

    // R3 write-only collision
    s = base_ld(); s.dst = 4'd3; s.dst_we = 1;
    hazard_pair(s, 1'b0, "R3 waw");

    // R9 unrelated / use bits clear / ex invalid / two slots behind
    s = base_ld(); s.src_a_use = 1; s.src_b_use = 1; s.dst_we = 1; s.ptr_use = 1;
    quiet(s, "R9 no match");
    s = base_ld(); s.src_a = 4'd3; s.src_b = 4'd3; s.dst = 4'd3; s.ptr = 4'd3;
    quiet(s, "R9 use bits clear");
    s = base_ld(); s.src_a = 4'd3; s.src_a_use = 1; s.ex_valid = 0;
    quiet(s, "R9 ex invalid");
    s = base_ld();
    drive(s, 1'b0, 1'b0, "R9 gap slot");
    t = idle(); t.ex_valid = 1; t.src_a = 4'd3; t.src_a_use = 1;
    drive(t, 1'b0, 1'b0, "R9 two behind");

    // R4 status-register load
    s = base_ld(); s.ld_sr = 1; s.flag_rd = 1;
    hazard_pair(s, 1'b0, "R4 flag read");
    s = base_ld(); s.ld_sr = 1; s.src_a = 4'd3; s.src_a_use = 1; s.dst = 4'd3; s.dst_we = 1;
    quiet(s, "R4 gpr ignored");
    s = base_ld(); s.flag_rd = 1;
    quiet(s, "R4 flag no sr");

    // R5 load after load
    s = base_ld(); s.is_load = 1; s.dst = 4'd3; s.dst_we = 1; s.ptr = 4'd5; s.ptr_use = 1;
    quiet(s, "R5 same dst exempt");
    s = base_ld(); s.is_load = 1; s.dst = 4'd3; s.dst_we = 1; s.ptr = 4'd3; s.ptr_use = 1;
    hazard_pair(s, 1'b1, "R5 ptr still");

    // R6 multiply-accumulate
    s = base_ld(); s.is_mac = 1; s.ptr = 4'd3; s.ptr_use = 1; s.dst = 4'd3; s.dst_we = 1;
    s.src_b = 4'd6; s.src_b_use = 1;
    quiet(s, "R6 mac ptr exempt");
    s = base_ld(); s.is_mac = 1; s.ptr = 4'd3; s.ptr_use = 1; s.src_b = 4'd3; s.src_b_use = 1;
    hazard_pair(s, 1'b0, "R6 mac src_b");

    // R8 pointer hold over a busy load, R7 length k=2 -> 4 cycles
    s = base_ld(); s.ptr = 4'd3; s.ptr_use = 1; s.busy = 1;
    drive(s, 1'b1, 1'b1, "R8 busy0");
    drive(s, 1'b1, 1'b1, "R8 busy1");
    s.busy = 0;
    drive(s, 1'b1, 1'b1, "R8 last ma");
    s.ld_valid = 0;
    drive(s, 1'b1, 1'b0, "R8 tail no hold");
    drive(idle(), 1'b0, 1'b0, "R7 end");

    // R7 length k=3 with operand hazard
    s = base_ld(); s.src_a = 4'd3; s.src_a_use = 1; s.busy = 1;
    for (int i = 0; i < 3; i++) drive(s, 1'b1, 1'b0, "R7 busy");
    s.busy = 0;
    drive(s, 1'b1, 1'b0, "R7 last ma");
    s.ld_valid = 0;
    drive(s, 1'b1, 1'b0, "R7 tail");
    drive(s, 1'b0, 1'b0, "R7 released");
    drive(idle(), 1'b0, 1'b0, "R7 idle");

    wait (q.size() == 0);
    @(negedge clk);
    #2;
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule